// File: doc/BRIEF.md
# Buffered Compare PWM Timer Channel

This block is a single up-counting timer channel that produces one PWM output. Two compare registers set the waveform. The period register (B) returns the counter to zero when they match. The duty register (A) drives the output high when they match. The counter clear drives the output low again.

Each compare register can be paired with a shadow register: C shadows A, and D shadows B. When a pair is enabled, software writes the next value into the shadow register. The hardware copies it into the live register at a chosen moment. For A, that moment is either A's own compare match or the counter clear. For B, it is always the clear, because B's own match is the clear. A duty or period change therefore never lands in the middle of a period.

Setup uses a plain register-write port of address, data and a strobe. The port has no handshake, and every write is taken in the cycle its strobe is seen. Setting the start bit is the last step of setup.

Top module: `pwm_buf_timer`

## Requirements
- R1: After reset the counter reads 0, the output is 0, the control bits are all 0, and registers A, B, C and D each hold 16'hFFFF. With no other write, starting the channel makes the counter climb past 20 while the output stays 0.
- R2: Control register address 0 holds four bits: bit 0 is start, bit 1 pairs C with A, bit 2 pairs D with B, and bit 3 selects the copy moment for A (1 means at the counter clear, 0 means at A's match). While start is 0, the counter and the output hold their values.
- R3: While running, the counter adds 1 on each clock. In the cycle the counter equals B, the next edge loads 0 instead. The period is therefore B+1 cycles.
- R4: The edge after the counter equals A sets the output to 1. The edge that clears the counter sets it to 0. For A < B, the output is high for B−A of the B+1 cycles.
- R5: If A equals B, the clear wins and the output stays 0. If A is greater than B, the output also stays 0.
- R6: With A paired and bit 3 set to 1, C is copied into A on the clearing edge, so the new duty starts with the next period.
- R7: With A paired and bit 3 set to 0, C is copied into A on the edge of A's own match. A value written to C after that match waits one more period.
- R8: With B paired, D is copied into B on the clearing edge, so the new period starts with the next period.
- R9: The write addresses are 1 for A, 2 for B, 3 for C and 4 for D. A write to C or D never changes the live compare value. A write to A or B takes effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, taken in the same cycle |
| wr_addr | input | 3 | Register address (0 = control, 1 to 4 = A, B, C, D) |
| wr_data | input | 16 | Write data |
| cnt_o | output | 16 | Current counter value |
| pwm_o | output | 1 | PWM output |

## Verification
A write lands on the edge that samples its strobe. The counter moves on that same edge and a match is decided from the current count, so the output changes on the edge after the compare equality. A shadow copy is visible from the first period that follows it.

The bench drives inputs and samples at the falling edge. Each period is measured as the falling-edge samples from one zero count to the next. The expected high count is then the samples with count in A+1 to B. Mid-period writes are placed at a known sample index, so their effect is predicted per period rather than per edge.

// File: rtl/pwm_buf_pkg.sv
package pwm_buf_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_A    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_B    = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_C    = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_D    = 3'd4;

  typedef struct packed {
    logic at_clear;
    logic pair_b;
    logic pair_a;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_buf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              hit_a,
  input  logic              hit_b,
  output ctrl_t             ctrl_o,
  output logic [W-1:0]      live_a_o,
  output logic [W-1:0]      live_b_o
);
  localparam logic [W-1:0] INIT = {W{1'b1}};

  ctrl_t        ctrl_q;
  logic [W-1:0] a_q, b_q, c_q, d_q;
  logic         load_a, load_b;

  assign load_a = ctrl_q.pair_a && (ctrl_q.at_clear ? hit_b : hit_a);
  assign load_b = ctrl_q.pair_b && hit_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      a_q    <= INIT;
      b_q    <= INIT;
      c_q    <= INIT;
      d_q    <= INIT;
    end else begin
      if (wr_en && wr_addr == ADR_CTRL) ctrl_q <= ctrl_t'(wr_data[3:0]);
      if (wr_en && wr_addr == ADR_C)    c_q    <= wr_data;
      if (wr_en && wr_addr == ADR_D)    d_q    <= wr_data;
      if (load_a)                            a_q <= c_q;
      else if (wr_en && wr_addr == ADR_A)    a_q <= wr_data;
      if (load_b)                            b_q <= d_q;
      else if (wr_en && wr_addr == ADR_B)    b_q <= wr_data;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign live_a_o = a_q;
  assign live_b_o = b_q;

  p_copy_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.pair_a && ctrl_q.at_clear && hit_b) |=> (a_q == $past(c_q)));
  p_copy_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.pair_a && !ctrl_q.at_clear && hit_a) |=> (a_q == $past(c_q)));
  p_copy_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.pair_b && hit_b) |=> (b_q == $past(d_q)));
  p_shadow_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADR_C || wr_addr == ADR_D) && !hit_a && !hit_b)
      |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] live_a,
  input  logic [W-1:0] live_b,
  output logic [W-1:0] cnt_o,
  output logic         hit_a_o,
  output logic         hit_b_o
);
  logic [W-1:0] cnt_q;

  assign hit_a_o = run && (cnt_q == live_a);
  assign hit_b_o = run && (cnt_q == live_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (hit_b_o) cnt_q <= '0;
    else if (run)     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_hold_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q == live_b) |=> (cnt_q == '0));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q != live_b) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pwm_out.sv
module pwm_out (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_a,
  input  logic hit_b,
  output logic pwm_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lvl_q <= 1'b0;
    else if (hit_b) lvl_q <= 1'b0;
    else if (hit_a) lvl_q <= 1'b1;
  end

  assign pwm_o = lvl_q;

  p_hold_lvl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_a && !hit_b) |=> $stable(lvl_q));
  p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && !hit_b) |=> lvl_q);
  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b |=> !lvl_q);
endmodule

// File: rtl/pwm_buf_timer.sv
module pwm_buf_timer
  import pwm_buf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      cnt_o,
  output logic              pwm_o
);
  ctrl_t        ctrl;
  logic [W-1:0] live_a, live_b;
  logic         hit_a, hit_b;

  pwm_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hit_a(hit_a), .hit_b(hit_b),
    .ctrl_o(ctrl), .live_a_o(live_a), .live_b_o(live_b)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .live_a(live_a),
    .live_b(live_b), .cnt_o(cnt_o), .hit_a_o(hit_a), .hit_b_o(hit_b)
  );

  pwm_out u_out (
    .clk(clk), .rst_n(rst_n), .hit_a(hit_a), .hit_b(hit_b), .pwm_o(pwm_o)
  );
endmodule

// File: tb/sim_pwm_buf_timer.sv
`timescale 1ns/1ps
module sim_pwm_buf_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt;
  logic        pwm;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_buf_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt), .pwm_o(pwm)
  );

  localparam int NV = 7;
  localparam logic [15:0] VEC_A [NV] = '{16'd2, 16'd0, 16'd3, 16'd7, 16'd0, 16'd5, 16'd1};
  localparam logic [15:0] VEC_B [NV] = '{16'd9, 16'd5, 16'd3, 16'd4, 16'd0, 16'd20, 16'd2};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int wr_at, input logic [2:0] a, input logic [15:0] d,
                         output int len, output int high);
    len = 0; high = 0;
    do begin
      high += int'(pwm);
      len++;
      if (len - 1 == wr_at) begin
        wr_en = 1'b1; wr_addr = a; wr_data = d;
      end
      @(negedge clk);
      wr_en = 1'b0;
    end while (cnt != 16'd0 && len < 70000);
  endtask

  initial begin
    int len, high, eh;
    do_reset();
    check("R1 cnt after reset", int'(cnt), 0);
    check("R1 pwm after reset", int'(pwm), 0);
    wr(3'd0, 16'h0001);
    repeat (20) @(negedge clk);
    check("R1 regs all ones: cnt climbs", int'(cnt), 20);
    check("R1 regs all ones: pwm low", int'(pwm), 0);

    // R3 R4 R5: table of {A,B} walked by one loop, buffering off
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(3'd1, VEC_A[i]);
      wr(3'd2, VEC_B[i]);
      wr(3'd0, 16'h0001);
      measure(-1, 3'd0, 16'd0, len, high);
      eh = (VEC_A[i] < VEC_B[i]) ? int'(VEC_B[i]) - int'(VEC_A[i]) : 0;
      check("R3 period length", len, int'(VEC_B[i]) + 1);
      check(VEC_A[i] < VEC_B[i] ? "R4 high cycles" : "R5 high cycles", high, eh);
    end

    // R2: stop holds counter and output
    do_reset();
    wr(3'd1, 16'd2); wr(3'd2, 16'd9); wr(3'd0, 16'h0001);
    repeat (5) @(negedge clk);
    wr(3'd0, 16'h0000);
    check("R2 cnt at stop", int'(cnt), 6);
    check("R2 pwm at stop", int'(pwm), 1);
    repeat (5) @(negedge clk);
    check("R2 cnt held", int'(cnt), 6);
    check("R2 pwm held", int'(pwm), 1);

    // R6 R9: pair A, copy at clear; C write mid-period leaves A alone
    do_reset();
    wr(3'd1, 16'd2); wr(3'd2, 16'd9); wr(3'd3, 16'd5);
    wr(3'd0, 16'h000B);
    measure(1, 3'd3, 16'd6, len, high);
    check("R9 C write no effect", high, 7);
    measure(-1, 3'd0, 16'd0, len, high);
    check("R6 copy at clear", high, 3);

    // R7: pair A, copy on A match
    do_reset();
    wr(3'd1, 16'd2); wr(3'd2, 16'd9); wr(3'd3, 16'd4);
    wr(3'd0, 16'h0003);
    measure(5, 3'd3, 16'd6, len, high);
    check("R7 period1", high, 7);
    measure(-1, 3'd0, 16'd0, len, high);
    check("R7 period2 uses early C", high, 5);
    measure(-1, 3'd0, 16'd0, len, high);
    check("R7 period3 uses late C", high, 3);

    // R8: pair B with D
    do_reset();
    wr(3'd1, 16'd2); wr(3'd2, 16'd9); wr(3'd4, 16'd4);
    wr(3'd0, 16'h0005);
    measure(-1, 3'd0, 16'd0, len, high);
    check("R8 period1 length", len, 10);
    measure(-1, 3'd0, 16'd0, len, high);
    check("R8 period2 length", len, 5);
    check("R8 period2 high", high, 2);

    // R9: unbuffered A write takes effect at once
    do_reset();
    wr(3'd1, 16'd2); wr(3'd2, 16'd9); wr(3'd0, 16'h0001);
    measure(1, 3'd1, 16'd6, len, high);
    check("R9 direct A write", high, 3);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule